// File: doc/BRIEF.md
# Configuration Request Bus Router

This block makes the routing decision for configuration requests at one port of a bridge or switch in a tree of buses. It holds three programmable bus numbers: the upstream segment the port sits on (primary), the segment directly beneath it (secondary), and the highest-numbered segment reachable beneath it (subordinate). Every incoming request names a target by bus, device and function, plus a register offset. The request also carries a kind bit. A local request addresses a device on the segment where it arrives. A remote request addresses a device on some other segment.

Each accepted request has exactly one outcome. The port claims it for its own function. It turns it into a local request on the secondary segment. It passes it downstream unchanged. Or it discards it. Requests arrive on a valid/ready channel. Routed requests leave on a registered valid/ready channel. A local claim is signalled by a one-cycle strobe that carries the function and offset. The bus numbers are loaded through a simple write port, and they are also driven out so that neighbouring logic can use them. The offset is 12 bits wide when the extended configuration space is enabled, and 8 bits wide when it is not.

Top module: `cfg_router`

## Requirements
- R1: While rst_ni is low, and directly after it rises, all three bus-number outputs are 0, dn_valid_o is 0 and claim_o is 0.
- R2: When wr_en_i is high at a clock edge, wr_sel_i selects the register that takes wr_data_i: 0 selects primary, 1 selects secondary and 2 selects subordinate. The new value appears on the matching output after that edge. A write with wr_sel_i equal to 3 changes none of the three registers.
- R3: A remote request (req_kind_i=1) whose bus equals a nonzero secondary number is presented on the downstream channel in the cycle after it is accepted. It leaves with dn_kind_o=0, and its bus, device, function and offset are unchanged.
- R4: A remote request whose bus is greater than the secondary number and no greater than the subordinate number is presented downstream in the cycle after acceptance, with every field unchanged and dn_kind_o=1.
- R5: A remote request whose bus is below the secondary number, or above both the secondary and subordinate numbers, is accepted. It raises neither dn_valid_o nor claim_o.
- R6: While the secondary number is 0, no remote request of any bus number raises dn_valid_o.
- R7: A local request (req_kind_i=0) with device 0 raises claim_o for exactly one cycle after it is accepted, with claim_fn_o and claim_off_o equal to the request's function and offset. It raises no dn_valid_o.
- R8: A local request with a nonzero device is accepted and raises neither claim_o nor dn_valid_o.
- R9: While dn_valid_o is high and dn_ready_i is low, dn_valid_o stays high and all downstream fields hold their values.
- R10: req_ready_o is low exactly when dn_valid_o is high and dn_ready_i is low. A request held at the input during such a stall is taken on the first edge where req_ready_o is high.
- R11: A single accepted request never produces both a claim strobe and a downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus-number register write strobe |
| wr_sel_i | input | 2 | Register select: 0 primary, 1 secondary, 2 subordinate, 3 none |
| wr_data_i | input | BUS_W | Value to write |
| pri_bus_o | output | BUS_W | Primary bus number |
| sec_bus_o | output | BUS_W | Secondary bus number |
| sub_bus_o | output | BUS_W | Subordinate bus number |
| req_valid_i | input | 1 | Incoming request valid |
| req_ready_o | output | 1 | Incoming request accepted when high with valid |
| req_kind_i | input | 1 | 0 local, 1 remote |
| req_bus_i | input | BUS_W | Target bus |
| req_dev_i | input | DEV_W | Target device |
| req_fn_i | input | FN_W | Target function |
| req_off_i | input | OFF_W | Register offset |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream ready |
| dn_kind_o | output | 1 | Downstream request kind |
| dn_bus_o | output | BUS_W | Downstream target bus |
| dn_dev_o | output | DEV_W | Downstream target device |
| dn_fn_o | output | FN_W | Downstream target function |
| dn_off_o | output | OFF_W | Downstream register offset |
| claim_o | output | 1 | One-cycle local claim strobe |
| claim_fn_o | output | FN_W | Function of the claimed request |
| claim_off_o | output | OFF_W | Offset of the claimed request |

## Verification
The assertions check the following on every cycle. The downstream request holds steady under backpressure. Every claim strobe follows the acceptance of a local request to device 0. Every new downstream request follows the acceptance of a remote request while the secondary number is nonzero. A claim and a new downstream request never come from the same acceptance. Only the bench's scenarios can show that the range decision is correct. That covers the exact boundaries at the secondary and subordinate numbers, the conversion of the kind bit, field preservation, the write-select encoding and the reload of a stalled request. The bench checks these against its own model of the decision.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  typedef enum logic [1:0] {
    RT_DROP    = 2'd0,
    RT_CLAIM   = 2'd1,
    RT_CONVERT = 2'd2,
    RT_FORWARD = 2'd3
  } route_e;

  localparam logic KIND_LOCAL  = 1'b0;
  localparam logic KIND_REMOTE = 1'b1;

  localparam int NUM_BUSREGS = 3;
  localparam logic [1:0] SEL_PRI = 2'd0;
  localparam logic [1:0] SEL_SEC = 2'd1;
  localparam logic [1:0] SEL_SUB = 2'd2;
endpackage

// File: rtl/cfg_busnum_regs.sv
module cfg_busnum_regs
  import cfg_router_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [BUS_W-1:0] pri_o,
  output logic [BUS_W-1:0] sec_o,
  output logic [BUS_W-1:0] sub_o
);
  logic [BUS_W-1:0] num_q [NUM_BUSREGS];

  for (genvar g = 0; g < NUM_BUSREGS; g++) begin : g_num
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   num_q[g] <= '0;
      else if (wr_en_i && (wr_sel_i == 2'(g)))       num_q[g] <= wr_data_i;
    end
  end

  assign pri_o = num_q[SEL_PRI];
  assign sec_o = num_q[SEL_SEC];
  assign sub_o = num_q[SEL_SUB];

  // R2
  sel_none_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3) |=> ($stable(pri_o) && $stable(sec_o) && $stable(sub_o)));
endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
  import cfg_router_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5
) (
  input  logic             kind_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [BUS_W-1:0] sec_i,
  input  logic [BUS_W-1:0] sub_i,
  output route_e           route_o
);
  logic sec_set, hit_sec, in_sub;

  assign sec_set = (sec_i != '0);
  assign hit_sec = (bus_i == sec_i);
  assign in_sub  = (bus_i > sec_i) && (bus_i <= sub_i);

  always_comb begin
    route_o = RT_DROP;
    if (kind_i == KIND_LOCAL) begin
      // only device 0 on the arriving segment is this port's own function
      if (dev_i == '0) route_o = RT_CLAIM;
    end else if (sec_set) begin
      if (hit_sec)     route_o = RT_CONVERT;
      else if (in_sub) route_o = RT_FORWARD;
    end
  end
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         space_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign space_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R9
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter bit EXT_CFG_EN = 1'b1,
  localparam int OFF_W     = EXT_CFG_EN ? 12 : 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [BUS_W-1:0] pri_bus_o,
  output logic [BUS_W-1:0] sec_bus_o,
  output logic [BUS_W-1:0] sub_bus_o,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_kind_i,
  input  logic [BUS_W-1:0] req_bus_i,
  input  logic [DEV_W-1:0] req_dev_i,
  input  logic [FN_W-1:0]  req_fn_i,
  input  logic [OFF_W-1:0] req_off_i,
  output logic             dn_valid_o,
  input  logic             dn_ready_i,
  output logic             dn_kind_o,
  output logic [BUS_W-1:0] dn_bus_o,
  output logic [DEV_W-1:0] dn_dev_o,
  output logic [FN_W-1:0]  dn_fn_o,
  output logic [OFF_W-1:0] dn_off_o,
  output logic             claim_o,
  output logic [FN_W-1:0]  claim_fn_o,
  output logic [OFF_W-1:0] claim_off_o
);
  localparam int DN_W = 1 + BUS_W + DEV_W + FN_W + OFF_W;

  logic [BUS_W-1:0] pri_bus, sec_bus, sub_bus;
  route_e           route;
  logic             in_fire, space, dn_load, out_kind;
  logic [DN_W-1:0]  dn_in, dn_out;

  cfg_busnum_regs #(.BUS_W(BUS_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .pri_o(pri_bus), .sec_o(sec_bus), .sub_o(sub_bus)
  );

  cfg_route_decode #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_dec (
    .kind_i(req_kind_i), .bus_i(req_bus_i), .dev_i(req_dev_i),
    .sec_i(sec_bus), .sub_i(sub_bus), .route_o(route)
  );

  assign req_ready_o = space;
  assign in_fire     = req_valid_i && space;
  assign dn_load     = in_fire && (route == RT_CONVERT || route == RT_FORWARD);
  assign out_kind    = (route == RT_CONVERT) ? KIND_LOCAL : req_kind_i;
  assign dn_in       = {out_kind, req_bus_i, req_dev_i, req_fn_i, req_off_i};

  cfg_out_stage #(.W(DN_W)) u_out (
    .clk_i, .rst_ni, .load_i(dn_load), .data_i(dn_in), .ready_i(dn_ready_i),
    .space_o(space), .valid_o(dn_valid_o), .data_o(dn_out)
  );

  assign {dn_kind_o, dn_bus_o, dn_dev_o, dn_fn_o, dn_off_o} = dn_out;

  logic             claim_q;
  logic [FN_W-1:0]  claim_fn_q;
  logic [OFF_W-1:0] claim_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_q     <= 1'b0;
      claim_fn_q  <= '0;
      claim_off_q <= '0;
    end else begin
      claim_q <= in_fire && (route == RT_CLAIM);
      if (in_fire && route == RT_CLAIM) begin
        claim_fn_q  <= req_fn_i;
        claim_off_q <= req_off_i;
      end
    end
  end

  assign claim_o     = claim_q;
  assign claim_fn_o  = claim_fn_q;
  assign claim_off_o = claim_off_q;
  assign pri_bus_o   = pri_bus;
  assign sec_bus_o   = sec_bus;
  assign sub_bus_o   = sub_bus;

  // R7
  claim_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> $past(req_valid_i && req_ready_o && req_kind_i == KIND_LOCAL && req_dev_i == '0));

  // R3 R4
  dn_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_valid_o) |-> $past(req_valid_i && req_ready_o && req_kind_i == KIND_REMOTE));

  // R6
  dn_needs_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_valid_o) |-> $past(sec_bus_o != '0));

  // R11
  single_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(claim_o && $rose(dn_valid_o)));
endmodule

// File: tb/cfg_router_bench.sv
module cfg_router_bench;
  localparam int BUS_W = 8, DEV_W = 5, FN_W = 3, OFF_W = 12;

  logic clk = 0, rst_ni = 0;
  always #5 clk = ~clk;

  logic             wr_en = 0;
  logic [1:0]       wr_sel = 0;
  logic [BUS_W-1:0] wr_data = 0;
  logic [BUS_W-1:0] pri_bus, sec_bus, sub_bus;
  logic             req_valid = 0, req_ready, req_kind = 0;
  logic [BUS_W-1:0] req_bus = 0;
  logic [DEV_W-1:0] req_dev = 0;
  logic [FN_W-1:0]  req_fn = 0;
  logic [OFF_W-1:0] req_off = 0;
  logic             dn_valid, dn_ready = 1, dn_kind;
  logic [BUS_W-1:0] dn_bus;
  logic [DEV_W-1:0] dn_dev;
  logic [FN_W-1:0]  dn_fn;
  logic [OFF_W-1:0] dn_off;
  logic             claim;
  logic [FN_W-1:0]  claim_fn;
  logic [OFF_W-1:0] claim_off;

  cfg_router u_cfg_router (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .pri_bus_o(pri_bus), .sec_bus_o(sec_bus), .sub_bus_o(sub_bus),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_bus_i(req_bus), .req_dev_i(req_dev), .req_fn_i(req_fn), .req_off_i(req_off),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_kind_o(dn_kind),
    .dn_bus_o(dn_bus), .dn_dev_o(dn_dev), .dn_fn_o(dn_fn), .dn_off_o(dn_off),
    .claim_o(claim), .claim_fn_o(claim_fn), .claim_off_o(claim_off)
  );

  int total = 0, bad = 0;
  int m_pri = 0, m_sec = 0, m_sub = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 drop, 1 claim, 2 convert, 3 forward
  function automatic int model(input bit kind, input int bus, input int dev);
    if (!kind) return (dev == 0) ? 1 : 0;
    if (m_sec == 0) return 0;
    if (bus == m_sec) return 2;
    if (bus > m_sec && bus <= m_sub) return 3;
    return 0;
  endfunction

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = BUS_W'(val);
    @(negedge clk);
    wr_en = 0;
    if (sel == 0) m_pri = val; else if (sel == 1) m_sec = val; else if (sel == 2) m_sub = val;
  endtask

  task automatic send(input bit kind, input int bus, input int dev, input int fn,
                      input int off, input string tag);
    int exp;
    exp = model(kind, bus, dev);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_bus = BUS_W'(bus); req_dev = DEV_W'(dev);
    req_fn = FN_W'(fn); req_off = OFF_W'(off);
    chk(req_ready == 1, {tag, " R10 ready"}, req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(claim == (exp == 1), {tag, " claim"}, claim, exp == 1);
    chk(dn_valid == (exp >= 2), {tag, " dn_valid"}, dn_valid, exp >= 2);
    if (exp == 1)
      chk(claim_fn == FN_W'(fn) && claim_off == OFF_W'(off), {tag, " R7 claim fields"},
          {claim_fn, claim_off}, {FN_W'(fn), OFF_W'(off)});
    if (exp >= 2) begin
      chk(dn_kind == (exp == 3), {tag, " kind"}, dn_kind, exp == 3);
      chk(dn_bus == BUS_W'(bus) && dn_dev == DEV_W'(dev) && dn_fn == FN_W'(fn) &&
          dn_off == OFF_W'(off), {tag, " fields"},
          {dn_bus, dn_dev, dn_fn, dn_off}, {BUS_W'(bus), DEV_W'(dev), FN_W'(fn), OFF_W'(off)});
    end
    if (exp == 1) begin
      @(negedge clk);
      chk(claim == 0, {tag, " R7 single pulse"}, claim, 0);
    end
  endtask

  initial begin
    int dn_hold;
    void'($urandom(32'd4711));
    #3;
    // R1
    chk(pri_bus == 0 && sec_bus == 0 && sub_bus == 0, "R1 regs in reset",
        {pri_bus, sec_bus, sub_bus}, 0);
    chk(dn_valid == 0 && claim == 0, "R1 outputs in reset", {dn_valid, claim}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(pri_bus == 0 && sec_bus == 0 && sub_bus == 0 && !dn_valid && !claim,
        "R1 after reset", {pri_bus, sec_bus, sub_bus}, 0);

    // R6: secondary zero, nothing forwarded
    send(1, 0, 1, 0, 8, "R6 bus0");
    send(1, 5, 1, 0, 8, "R6 bus5");
    wr(2, 200);
    send(1, 100, 2, 1, 16, "R6 sub set sec zero");

    // R2
    wr(0, 3); wr(1, 4); wr(2, 9);
    chk(pri_bus == 3 && sec_bus == 4 && sub_bus == 9, "R2 write three",
        {pri_bus, sec_bus, sub_bus}, {8'd3, 8'd4, 8'd9});
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd3; wr_data = 8'hAA;
    @(negedge clk);
    wr_en = 0;
    chk(pri_bus == 3 && sec_bus == 4 && sub_bus == 9, "R2 sel3 ignored",
        {pri_bus, sec_bus, sub_bus}, {8'd3, 8'd4, 8'd9});

    // directed boundaries
    send(1, 4, 7, 2, 12'hABC, "R3 convert at sec");
    send(1, 5, 1, 3, 12'h104, "R4 just above sec");
    send(1, 9, 0, 7, 12'hFFF, "R4 at sub");
    send(1, 10, 0, 0, 4, "R5 above sub");
    send(1, 3, 0, 0, 4, "R5 below sec");
    send(0, 4, 0, 5, 12'h040, "R7 local dev0");
    send(0, 4, 3, 5, 12'h040, "R8 local dev3");

    // R9 R10: stall with a second request waiting
    dn_ready = 0;
    send(1, 6, 2, 1, 12'h200, "R9 first");
    @(negedge clk);
    req_valid = 1; req_kind = 1; req_bus = 8; req_dev = 9; req_fn = 4; req_off = 12'h300;
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 0, "R10 not ready while stalled", req_ready, 0);
      chk(dn_valid && dn_bus == 6 && dn_dev == 2 && dn_off == 12'h200, "R9 hold",
          {dn_valid, dn_bus}, {1'b1, 8'd6});
      @(negedge clk);
    end
    dn_ready = 1;
    #1;
    chk(req_ready == 1, "R10 ready on release", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(dn_valid && dn_bus == 8 && dn_dev == 9 && dn_kind == 1, "R10 second taken",
        {dn_valid, dn_bus, dn_dev}, {1'b1, 8'd8, 5'd9});
    @(negedge clk);
    chk(dn_valid == 0, "R9 drained", dn_valid, 0);

    // random mix (R3 R4 R5 R7 R8 R11)
    for (int n = 0; n < 300; n++) begin
      bit k;
      int b;
      if (n % 60 == 0) begin
        int s;
        s = 1 + ($urandom % 100);
        wr(1, s);
        wr(2, s + ($urandom % 20));
      end
      k = $urandom % 4 != 0;
      b = ($urandom % 2) ? (m_sec + int'($urandom % 24) - 4) : int'($urandom % 256);
      if (b < 0) b = 0;
      if (b > 255) b = 255;
      send(k, b, ($urandom % 3 == 0) ? 0 : $urandom % 32, $urandom % 8,
           $urandom % 4096, "R11 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule